// File: doc/BRIEF.md
# Address Watchpoint and Out-of-Range Interrupt Unit

This unit observes access traffic on three memory ports: port 0 serves general on-chip RAM, port 1 an instruction tightly coupled memory and port 2 a data tightly coupled memory. Each port has its own watch register. The register holds a 16-bit watch field, which names one 8-byte granule, and a direction bit that selects whether read or write accesses are watched. An access that falls inside the watched granule with the selected direction records a watch-hit event for that port. An access whose address is at or above the allocated limit supplied for that port records an out-of-range event.

Events reach a status register only if the matching status-enable bit is set. Status bits stay set until software clears them by writing ones. A signal-enable register selects which latched status bits raise the single interrupt line. The interrupt is registered, so it follows the gated status by one clock.

Software uses a simple register bus. A write strobe with an address and data updates a register at the clock edge. Read data is returned combinationally for the address currently presented.

Top module: `wpi_watch_unit`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low. The register addresses are: 0 status, 1 status-enable, 2 signal-enable, and 3, 4, 5 the watch registers of ports 0, 1, 2.
- R2: A watch register keeps bit 0 as the direction bit and bits [16:1] as the watch field. All other bits read zero, whatever value was written.
- R3: Port p sets status bit 3+p when all of the following hold: the access is valid, access address bits [18:3] equal the watch field, the write flag equals the direction bit (0 means read, 1 means write), and status-enable bit 3+p is set. Address bits [2:0] do not take part in the compare. The status bit is visible from the clock edge that samples the access.
- R4: An access whose direction differs from the watched direction does not set the watch-hit bit, even when the address matches.
- R5: A valid access on port p whose address is greater than or equal to that port's limit input sets status bit p. An address one below the limit does not set it.
- R6: An event whose status-enable bit is clear leaves the status bit unchanged.
- R7: Writing to the status register clears each bit written as 1. Bits written as 0 keep their value.
- R8: If a new enabled event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R9: `irq_o` equals the OR of (status AND signal-enable) as it stood one clock earlier. With signal-enable zero, `irq_o` stays low even while status bits are set.
- R10: An event on one port sets only that port's status bits. A matching address on another port with a different watch field sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| acc_valid | input | 3 | Per-port access valid |
| acc_write | input | 3 | Per-port write flag (1 = write) |
| acc_addr | input | 3*ADDR_W | Per-port byte address, port p in slice [p*ADDR_W +: ADDR_W] |
| acc_limit | input | 3*ADDR_W | Per-port allocated limit, same slicing |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Some rules are checked by assertions on every cycle. A status bit never rises unless its enable bit was set. An enabled event always leaves its bit set on the next cycle, even when a clear is written in that cycle. A clear with no competing event drops the bit. A matching watch access or an out-of-range access always sets the correct status bit. With signal-enable at zero, the interrupt stays low on the next cycle. Other behaviour can only be shown by the bench scenarios: the watch register readback format, that address bits [2:0] are ignored, an adjacent granule that does not match, the boundary just below the limit, isolation between ports, and the exact cycle at which the interrupt rises and falls.

// File: rtl/wpi_pkg.sv
package wpi_pkg;

   // number of watched memory ports
   localparam int unsigned NPORT   = 3;
   // status layout: [NPORT-1:0] out-of-range, [2*NPORT-1:NPORT] watch hit
   localparam int unsigned STAT_W  = 2 * NPORT;
   localparam int unsigned OOR_LSB = 0;
   localparam int unsigned HIT_LSB = NPORT;
   // register address space
   localparam int unsigned RA_W       = 3;
   localparam int unsigned WATCH_BASE = 3;

   typedef enum logic [RA_W-1:0] {
      RA_STATUS = 3'd0,
      RA_STAT_EN = 3'd1,
      RA_SIG_EN = 3'd2
   } reg_sel_e;

   // direction encodings for the watch register
   localparam logic DIR_READ  = 1'b0;
   localparam logic DIR_WRITE = 1'b1;

endpackage

// File: rtl/wpi_port_watch.sv
module wpi_port_watch
   import wpi_pkg::*;
#(
   parameter int unsigned ADDR_W   = 20,
   parameter int unsigned GRAN_LSB = 3,
   parameter int unsigned GRAN_W   = 16
) (
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [ADDR_W-1:0] acc_limit,
   input  logic [GRAN_W-1:0] watch_gran,
   input  logic              watch_dir,
   output logic              hit_o,
   output logic              oor_o
);

   localparam int unsigned GRAN_MSB = GRAN_LSB + GRAN_W - 1;

   logic gran_eq;
   logic dir_eq;

   assign gran_eq = (acc_addr[GRAN_MSB:GRAN_LSB] == watch_gran);
   assign dir_eq  = (acc_write == watch_dir);
   assign hit_o   = acc_valid && gran_eq && dir_eq;
   assign oor_o   = acc_valid && (acc_addr >= acc_limit);

endmodule

// File: rtl/wpi_regs.sv
module wpi_regs
   import wpi_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned GRAN_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic [RA_W-1:0]               reg_addr,
   input  logic [DATA_W-1:0]             reg_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   input  logic [STAT_W-1:0]             event_i,
   output logic [STAT_W-1:0]             status_o,
   output logic [STAT_W-1:0]             stat_en_o,
   output logic [STAT_W-1:0]             sig_en_o,
   output logic [NPORT-1:0][GRAN_W-1:0]  watch_gran_o,
   output logic [NPORT-1:0]              watch_dir_o
);

   localparam int unsigned WATCH_W = GRAN_W + 1;

   logic [STAT_W-1:0]            stat_q;
   logic [STAT_W-1:0]            sten_q;
   logic [STAT_W-1:0]            sgen_q;
   logic [NPORT-1:0][GRAN_W-1:0] wgran_q;
   logic [NPORT-1:0]             wdir_q;

   logic              wr_status;
   logic [STAT_W-1:0] clr_mask;
   logic [STAT_W-1:0] set_mask;
   logic [STAT_W-1:0] stat_d;

   assign wr_status = reg_wr && (reg_addr == RA_STATUS);
   assign clr_mask  = wr_status ? reg_wdata[STAT_W-1:0] : '0;
   assign set_mask  = event_i & sten_q;
   // a fresh event overrides a clear of the same bit
   assign stat_d    = (stat_q & ~clr_mask) | set_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         sten_q <= '0;
         sgen_q <= '0;
      end else begin
         stat_q <= stat_d;
         if (reg_wr && reg_addr == RA_STAT_EN) sten_q <= reg_wdata[STAT_W-1:0];
         if (reg_wr && reg_addr == RA_SIG_EN)  sgen_q <= reg_wdata[STAT_W-1:0];
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_watch
      logic sel;
      assign sel = reg_wr && (reg_addr == RA_W'(WATCH_BASE + p));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wgran_q[p] <= '0;
            wdir_q[p]  <= 1'b0;
         end else if (sel) begin
            wgran_q[p] <= reg_wdata[GRAN_W:1];
            wdir_q[p]  <= reg_wdata[0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_STATUS:  reg_rdata = DATA_W'(stat_q);
         RA_STAT_EN: reg_rdata = DATA_W'(sten_q);
         RA_SIG_EN:  reg_rdata = DATA_W'(sgen_q);
         default: begin
            for (int i = 0; i < int'(NPORT); i++) begin
               if (reg_addr == RA_W'(WATCH_BASE + i))
                  reg_rdata = DATA_W'({wgran_q[i], wdir_q[i]});
            end
         end
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata[DATA_W-1:WATCH_W];

   assign status_o     = stat_q;
   assign stat_en_o    = sten_q;
   assign sig_en_o     = sgen_q;
   assign watch_gran_o = wgran_q;
   assign watch_dir_o  = wdir_q;

   for (genvar b = 0; b < STAT_W; b++) begin : g_chk
      // R6: a status bit only rises when its enable was set
      a_r6_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat_q[b]) |-> $past(sten_q[b]));
      // R8: an enabled event always leaves the bit set
      a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (event_i[b] && sten_q[b]) |=> stat_q[b]);
      // R7: clear without a competing event drops the bit
      a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_status && reg_wdata[b] && !(event_i[b] && sten_q[b])) |=> !stat_q[b]);
   end

endmodule

// File: rtl/wpi_irq.sv
module wpi_irq
   import wpi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] status_i,
   input  logic [STAT_W-1:0] sig_en_i,
   output logic              irq_o
);

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status_i & sig_en_i);
   end

   assign irq_o = irq_q;

   // R9: no signal enables means no interrupt on the next cycle
   a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_en_i == '0) |=> !irq_o);

endmodule

// File: rtl/wpi_watch_unit.sv
module wpi_watch_unit
   import wpi_pkg::*;
#(
   parameter int unsigned ADDR_W   = 20,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned GRAN_LSB = 3,
   parameter int unsigned GRAN_W   = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic [RA_W-1:0]         reg_addr,
   input  logic [DATA_W-1:0]       reg_wdata,
   output logic [DATA_W-1:0]       reg_rdata,
   input  logic [NPORT-1:0]        acc_valid,
   input  logic [NPORT-1:0]        acc_write,
   input  logic [NPORT*ADDR_W-1:0] acc_addr,
   input  logic [NPORT*ADDR_W-1:0] acc_limit,
   output logic                    irq_o
);

   localparam int unsigned GRAN_MSB = GRAN_LSB + GRAN_W - 1;

   if (ADDR_W < GRAN_MSB + 1) begin : g_bad_addr
      $error("wpi_watch_unit: ADDR_W too narrow for the watch field");
   end
   if (DATA_W < GRAN_W + 1) begin : g_bad_data
      $error("wpi_watch_unit: DATA_W too narrow for a watch register");
   end
   if (DATA_W < STAT_W) begin : g_bad_stat
      $error("wpi_watch_unit: DATA_W too narrow for the status register");
   end

   logic [STAT_W-1:0]            events;
   logic [STAT_W-1:0]            status;
   logic [STAT_W-1:0]            stat_en;
   logic [STAT_W-1:0]            sig_en;
   logic [NPORT-1:0][GRAN_W-1:0] watch_gran;
   logic [NPORT-1:0]             watch_dir;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic hit;
      logic oor;
      wpi_port_watch #(
         .ADDR_W  (ADDR_W),
         .GRAN_LSB(GRAN_LSB),
         .GRAN_W  (GRAN_W)
      ) u_watch (
         .acc_valid (acc_valid[p]),
         .acc_write (acc_write[p]),
         .acc_addr  (acc_addr[p*ADDR_W +: ADDR_W]),
         .acc_limit (acc_limit[p*ADDR_W +: ADDR_W]),
         .watch_gran(watch_gran[p]),
         .watch_dir (watch_dir[p]),
         .hit_o     (hit),
         .oor_o     (oor)
      );
      assign events[HIT_LSB + p] = hit;
      assign events[OOR_LSB + p] = oor;

      // R3: an enabled watch match lands in the port's hit bit
      a_r3_hit_latched: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid[p] && stat_en[HIT_LSB + p] && (acc_write[p] == watch_dir[p]) &&
          (acc_addr[p*ADDR_W + GRAN_LSB +: GRAN_W] == watch_gran[p]))
         |=> status[HIT_LSB + p]);
      // R5: an enabled out-of-range access lands in the port's range bit
      a_r5_oor_latched: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid[p] && stat_en[OOR_LSB + p] &&
          (acc_addr[p*ADDR_W +: ADDR_W] >= acc_limit[p*ADDR_W +: ADDR_W]))
         |=> status[OOR_LSB + p]);
   end

   wpi_regs #(
      .DATA_W(DATA_W),
      .GRAN_W(GRAN_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .event_i     (events),
      .status_o    (status),
      .stat_en_o   (stat_en),
      .sig_en_o    (sig_en),
      .watch_gran_o(watch_gran),
      .watch_dir_o (watch_dir)
   );

   wpi_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .status_i(status),
      .sig_en_i(sig_en),
      .irq_o   (irq_o)
   );

endmodule

// File: tb/wpi_watch_unit_bench.sv
`timescale 1ns/1ps
module wpi_watch_unit_bench;

   localparam int AW = 20;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [2:0]    acc_valid = '0;
   logic [2:0]    acc_write = '0;
   logic [3*AW-1:0] acc_addr = '0;
   logic [3*AW-1:0] acc_limit = '0;
   logic          irq_o;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   wpi_watch_unit u_wpi_watch_unit (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
      .acc_write(acc_write), .acc_addr(acc_addr), .acc_limit(acc_limit),
      .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic access(input int p, input logic [AW-1:0] a, input logic wr);
      @(negedge clk);
      acc_valid[p] = 1'b1; acc_write[p] = wr; acc_addr[p*AW +: AW] = a;
      @(negedge clk);
      acc_valid[p] = 1'b0;
   endtask

   task automatic expect_status(input string req, input logic [DW-1:0] exp);
      logic [DW-1:0] d;
      reg_read(3'd0, d);
      check(req, d, exp);
   endtask

   task automatic t_reset;
      logic [DW-1:0] d;
      for (int a = 0; a < 6; a++) begin
         reg_read(3'(a), d);
         check("R1 register reset", d, '0);
      end
      check("R1 irq reset", {31'd0, irq_o}, '0);
   endtask

   task automatic t_watch_format;
      logic [DW-1:0] d;
      reg_write(3'd3, 32'hFFFF_FFFF);
      reg_read(3'd3, d);
      check("R2 watch readback", d, 32'h0001_FFFF);
      reg_write(3'd3, 32'h0);
   endtask

   task automatic t_hit;
      reg_write(3'd1, 32'h3F);
      reg_write(3'd4, (32'h0246 << 1) | 32'h1);
      access(1, 20'h01235, 1'b1);
      expect_status("R3 watch hit port1 with low bits set", 32'h10);
      reg_write(3'd0, 32'h3F);
      expect_status("R7 clear after hit", 32'h0);
      access(1, 20'h01238, 1'b1);
      expect_status("R3 next granule no hit", 32'h0);
      access(0, 20'h01235, 1'b1);
      access(2, 20'h01235, 1'b1);
      expect_status("R10 other ports no hit", 32'h0);
   endtask

   task automatic t_dir;
      access(1, 20'h01235, 1'b0);
      expect_status("R4 direction mismatch", 32'h0);
   endtask

   task automatic t_range;
      acc_limit[0*AW +: AW] = 20'h00100;
      access(0, 20'h000FF, 1'b1);
      expect_status("R5 below limit", 32'h0);
      access(0, 20'h00100, 1'b1);
      expect_status("R5 at limit", 32'h01);
      reg_write(3'd0, 32'h01);
      acc_limit[2*AW +: AW] = 20'h00040;
      access(2, 20'h00080, 1'b0);
      expect_status("R5 R10 port2 range bit only", 32'h04);
      reg_write(3'd0, 32'h3F);
      acc_limit = {3{20'hFFFFF}};
   endtask

   task automatic t_mask;
      acc_limit[2*AW +: AW] = 20'h00040;
      reg_write(3'd1, 32'h3B);
      access(2, 20'h00080, 1'b0);
      access(1, 20'h01235, 1'b1);
      expect_status("R6 disabled bit not latched", 32'h10);
      reg_write(3'd0, 32'h3F);
      reg_write(3'd1, 32'h3F);
      acc_limit = {3{20'hFFFFF}};
   endtask

   task automatic t_w1c;
      acc_limit[0*AW +: AW] = 20'h00100;
      access(0, 20'h00200, 1'b1);
      access(1, 20'h01235, 1'b1);
      acc_limit = {3{20'hFFFFF}};
      expect_status("R5 R3 two bits set", 32'h11);
      reg_write(3'd0, 32'h0);
      expect_status("R7 zero write keeps", 32'h11);
      reg_write(3'd0, 32'h01);
      expect_status("R7 partial clear", 32'h10);
      reg_write(3'd0, 32'h10);
      expect_status("R7 full clear", 32'h0);
   endtask

   task automatic t_collision;
      access(1, 20'h01235, 1'b1);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h10;
      acc_valid[1] = 1'b1; acc_write[1] = 1'b1; acc_addr[1*AW +: AW] = 20'h01235;
      @(negedge clk);
      reg_wr = 1'b0; acc_valid[1] = 1'b0;
      expect_status("R8 hit beats clear", 32'h10);
   endtask

   task automatic t_irq;
      @(negedge clk); @(negedge clk);
      check("R9 no irq with signal enable zero", {31'd0, irq_o}, '0);
      reg_write(3'd2, 32'h01);
      @(negedge clk);
      check("R9 unrelated enable", {31'd0, irq_o}, '0);
      reg_write(3'd2, 32'h10);
      check("R9 irq one cycle after enable", {31'd0, irq_o}, '0);
      @(negedge clk);
      check("R9 irq raised", {31'd0, irq_o}, 32'h1);
      reg_write(3'd0, 32'h10);
      check("R9 irq held one cycle after clear", {31'd0, irq_o}, 32'h1);
      @(negedge clk);
      check("R9 irq dropped", {31'd0, irq_o}, '0);
   endtask

   initial begin
      acc_limit = {3{20'hFFFFF}};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_watch_format();
      t_hit();
      t_dir();
      t_range();
      t_mask();
      t_w1c();
      t_collision();
      t_irq();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule